// File: doc/BRIEF.md
# Region Access Permission Checker

This block decides, in the same cycle, whether a single bus access may proceed. An access arrives with its byte address, the number of the master that issued it, its kind (read, write or instruction fetch), the privilege level it runs at and a process tag. The block compares it against a set of region descriptors. Each descriptor holds a lower and an upper address bound, a packed rights word with one field per master, a process tag with a don't-care mask, and a valid bit.

Every valid region whose bounds contain the address, and whose tag test passes, counts as a hit. The rights field that belongs to the requesting master is decoded in each hit region. If any hit region permits the access kind, the access is granted. When the access is refused, a two-bit class tells whether no region was hit, one region was hit, or several overlapping regions were hit. A global enable set low turns protection off entirely.

Top module: `rgn_perm_chk`

## Requirements
- R1: While `global_en` is 0, `grant` is 1 and `err_class` is 0 for every access and descriptor setting.
- R2: A region hits only if its valid bit is set and `addr[31:5]` lies between `lo[31:5]` and `hi[31:5]` inclusive. The low five bits of `lo` are treated as 0 and those of `hi` as 1.
- R3: Masters 0 to 3 own the 6-bit field at bit 6×n of the rights word: bits [2:0] hold the user mask, [4:3] the supervisor code and [5] the tag enable. In the user mask, bit 2 permits read, bit 1 write and bit 0 execute, so the value 0 permits nothing. User-mode accesses (`acc_super`=0) use this mask.
- R4: For masters 0 to 3 in supervisor mode, supervisor code 0 permits read, write and execute, code 1 permits read and execute, code 2 permits read and write, and code 3 applies the user mask.
- R5: Masters 4 to 7 own the 2-bit field at bit 24+2×(n−4): bit 0 permits write and bit 1 permits read. They are never permitted to execute, their privilege level has no effect, and they have no tag enable.
- R6: When the master's tag enable is 1, a region hits only if `acc_pid` equals the region tag on every bit whose mask bit is 0. When the enable is 0, the tag plays no part.
- R7: When regions overlap, the access is granted if at least one hit region permits it.
- R8: With `global_en`=1, a granted access gives `grant`=1 and `err_class`=0. A refused access gives `grant`=0 with `err_class` 0 when no region hit, 1 when exactly one region hit, and 2 when two or more regions hit.
- R9: `grant` and `err_class` follow the request and descriptor inputs combinationally, with no clock edge in between.
- R10: Access kind code 3 (kind codes: 0 read, 1 write, 2 execute) is never permitted by any region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| global_en | input | 1 | Protection on (1) or off (0) |
| acc_addr | input | 32 | Byte address of the access |
| acc_master | input | 3 | Requesting master number |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| acc_super | input | 1 | 1 supervisor, 0 user |
| acc_pid | input | 8 | Process tag of the access |
| rgn_valid | input | 4 | Valid bit per region |
| rgn_lo | input | 128 | Lower bound per region, region r at [32r+:32] |
| rgn_hi | input | 128 | Upper bound per region |
| rgn_rights | input | 128 | Rights word per region |
| rgn_pid | input | 32 | Tag per region, region r at [8r+:8] |
| rgn_pid_mask | input | 32 | Tag don't-care mask per region |
| grant | output | 1 | Access permitted |
| err_class | output | 2 | Refusal class |

## Verification
The bench probes the addresses one below, at and one above both effective bounds, using bounds whose low five bits are not aligned. A design that ignored the rounding, or that used strict comparisons, would refuse the end bytes or accept the neighbouring ones. Each supervisor code is paired with a user mask that disagrees with it. A decoder that mixed up code 3 or swapped the read and write bits of the narrow fields would then grant the wrong kind. Overlapping regions with complementary rights show whether permissions are OR-combined or picked by priority, and whether the refusal class counts the hits. Tag tests with a partial mask catch a mask applied with the wrong polarity.

// File: rtl/rgn_chk_pkg.sv
package rgn_chk_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_EXEC  = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CLS_NO_HIT = 2'd0,
        CLS_ONE    = 2'd1,
        CLS_MULTI  = 2'd2,
        CLS_RSVD   = 2'd3
    } fail_cls_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    localparam int RIGHTS_W     = 32;
    localparam int PRIV_FIELD_W = 6;
    localparam int NORM_FIELD_W = 2;
    localparam int NORM_BASE    = 24;
    localparam int GRAN_BITS    = 5;

endpackage

// File: rtl/rgn_rights_dec.sv
module rgn_rights_dec
    import rgn_chk_pkg::*;
#(
    parameter int NUM_PRIV    = 4,
    parameter int NUM_MASTERS = 8,
    parameter int MW          = 3
) (
    input  logic [RIGHTS_W-1:0] rights,
    input  logic [MW-1:0]       master,
    input  logic                super_mode,
    output perm_t               perm,
    output logic                pid_en
);

    typedef struct packed {
        perm_t perm;
        logic  pid_en;
    } dec_t;

    dec_t                    dec_d;
    logic [PRIV_FIELD_W-1:0] pfield;
    logic [NORM_FIELD_W-1:0] nfield;
    logic                    is_priv;
    logic [1:0]              sup_code;
    logic [2:0]              user_mask;

    always_comb begin
        pfield  = '0;
        nfield  = '0;
        is_priv = 1'b0;
        for (int m = 0; m < NUM_PRIV; m++) begin
            if (master == MW'(m)) begin
                pfield  = rights[m*PRIV_FIELD_W +: PRIV_FIELD_W];
                is_priv = 1'b1;
            end
        end
        for (int m = NUM_PRIV; m < NUM_MASTERS; m++) begin
            if (master == MW'(m)) begin
                nfield = rights[NORM_BASE + (m-NUM_PRIV)*NORM_FIELD_W +: NORM_FIELD_W];
            end
        end

        user_mask = pfield[2:0];
        sup_code  = pfield[4:3];
        dec_d     = '0;

        if (is_priv) begin
            dec_d.pid_en = pfield[5];
            if (!super_mode) begin
                dec_d.perm = '{rd: user_mask[2], wr: user_mask[1], ex: user_mask[0]};
            end else begin
                unique case (sup_code)
                    2'd0:    dec_d.perm = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
                    2'd1:    dec_d.perm = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
                    2'd2:    dec_d.perm = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
                    default: dec_d.perm = '{rd: user_mask[2], wr: user_mask[1], ex: user_mask[0]};
                endcase
            end
        end else begin
            dec_d.perm = '{rd: nfield[1], wr: nfield[0], ex: 1'b0};
        end
    end

    assign perm   = dec_d.perm;
    assign pid_en = dec_d.pid_en;

    always_comb begin
        // R5
        if (master >= MW'(NUM_PRIV)) begin
            norm_no_exec_chk: assert (!perm.ex && !pid_en)
                else $error("narrow-field master obtained execute or tag enable");
        end
        // R4
        if (super_mode && master < MW'(NUM_PRIV) && rights[master*PRIV_FIELD_W + 3 +: 2] == 2'd0) begin
            sup_full_chk: assert (perm == 3'b111)
                else $error("supervisor code 0 did not give full rights");
        end
    end

endmodule

// File: rtl/rgn_bound_match.sv
module rgn_bound_match
    import rgn_chk_pkg::*;
#(
    parameter int AW = 32,
    parameter int PW = 8
) (
    input  logic          valid,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic          pid_en,
    input  logic [PW-1:0] acc_pid,
    input  logic [PW-1:0] rgn_pid,
    input  logic [PW-1:0] rgn_mask,
    output logic          hit
);

    localparam int UW = AW - GRAN_BITS;
    localparam logic [AW-1:0] LOW_ONES = AW'((1 << GRAN_BITS) - 1);

    logic [UW-1:0] addr_u, lo_u, hi_u;
    logic          in_range_d;
    logic          pid_ok_d;

    always_comb begin
        addr_u     = addr[AW-1:GRAN_BITS];
        lo_u       = lo[AW-1:GRAN_BITS];
        hi_u       = hi[AW-1:GRAN_BITS];
        in_range_d = (addr_u >= lo_u) && (addr_u <= hi_u);
        pid_ok_d   = !pid_en || (((acc_pid ^ rgn_pid) & ~rgn_mask) == '0);
    end

    assign hit = valid && in_range_d && pid_ok_d;

    always_comb begin
        // R2
        if (hit) begin
            bound_incl_chk: assert (((addr | LOW_ONES) >= lo) && ((addr & ~LOW_ONES) <= hi))
                else $error("hit outside the rounded bounds");
        end
        // R6
        if (hit && pid_en) begin
            pid_match_chk: assert ((acc_pid & ~rgn_mask) == (rgn_pid & ~rgn_mask))
                else $error("hit with a mismatching process tag");
        end
    end

endmodule

// File: rtl/rgn_resolve.sv
module rgn_resolve
    import rgn_chk_pkg::*;
#(
    parameter int NR = 4
) (
    input  logic          enable,
    input  logic [NR-1:0] hit,
    input  logic [NR-1:0] ok,
    output logic          grant,
    output logic [1:0]    err_class
);

    localparam int CW = $clog2(NR + 1);

    typedef struct packed {
        logic      grant;
        fail_cls_e cls;
    } res_t;

    res_t          res_d;
    logic [CW-1:0] n_hit;

    always_comb begin
        n_hit = '0;
        for (int r = 0; r < NR; r++) begin
            n_hit = n_hit + CW'(hit[r]);
        end
        res_d = '{grant: 1'b0, cls: CLS_NO_HIT};
        if (!enable || (ok != '0)) begin
            res_d.grant = 1'b1;
        end else if (n_hit == CW'(1)) begin
            res_d.cls = CLS_ONE;
        end else if (n_hit > CW'(1)) begin
            res_d.cls = CLS_MULTI;
        end
    end

    assign grant     = res_d.grant;
    assign err_class = res_d.cls;

    always_comb begin
        // R8
        cls_legal_chk: assert (err_class != CLS_RSVD)
            else $error("reserved refusal class");
    end

endmodule

// File: rtl/rgn_perm_chk.sv
module rgn_perm_chk
    import rgn_chk_pkg::*;
#(
    parameter int AW          = 32,
    parameter int NR          = 4,
    parameter int PW          = 8,
    parameter int MW          = 3,
    parameter int NUM_PRIV    = 4,
    parameter int NUM_MASTERS = 8
) (
    input  logic                   global_en,
    input  logic [AW-1:0]          acc_addr,
    input  logic [MW-1:0]          acc_master,
    input  logic [1:0]             acc_kind,
    input  logic                   acc_super,
    input  logic [PW-1:0]          acc_pid,
    input  logic [NR-1:0]          rgn_valid,
    input  logic [NR*AW-1:0]       rgn_lo,
    input  logic [NR*AW-1:0]       rgn_hi,
    input  logic [NR*RIGHTS_W-1:0] rgn_rights,
    input  logic [NR*PW-1:0]       rgn_pid,
    input  logic [NR*PW-1:0]       rgn_pid_mask,
    output logic                   grant,
    output logic [1:0]             err_class
);

    logic [NR-1:0] hit_vec;
    logic [NR-1:0] ok_vec;

    for (genvar r = 0; r < NR; r++) begin : g_rgn
        perm_t perm;
        logic  pid_en;
        logic  need_met_d;

        rgn_rights_dec #(
            .NUM_PRIV    (NUM_PRIV),
            .NUM_MASTERS (NUM_MASTERS),
            .MW          (MW)
        ) u_dec (
            .rights     (rgn_rights[r*RIGHTS_W +: RIGHTS_W]),
            .master     (acc_master),
            .super_mode (acc_super),
            .perm       (perm),
            .pid_en     (pid_en)
        );

        rgn_bound_match #(
            .AW (AW),
            .PW (PW)
        ) u_match (
            .valid    (rgn_valid[r]),
            .addr     (acc_addr),
            .lo       (rgn_lo[r*AW +: AW]),
            .hi       (rgn_hi[r*AW +: AW]),
            .pid_en   (pid_en),
            .acc_pid  (acc_pid),
            .rgn_pid  (rgn_pid[r*PW +: PW]),
            .rgn_mask (rgn_pid_mask[r*PW +: PW]),
            .hit      (hit_vec[r])
        );

        always_comb begin
            unique case (acc_kind)
                KIND_READ:  need_met_d = perm.rd;
                KIND_WRITE: need_met_d = perm.wr;
                KIND_EXEC:  need_met_d = perm.ex;
                default:    need_met_d = 1'b0;
            endcase
        end

        assign ok_vec[r] = hit_vec[r] && need_met_d;
    end

    rgn_resolve #(
        .NR (NR)
    ) u_res (
        .enable    (global_en),
        .hit       (hit_vec),
        .ok        (ok_vec),
        .grant     (grant),
        .err_class (err_class)
    );

    always_comb begin
        // R1
        if (!global_en) begin
            off_grant_chk: assert (grant && err_class == 2'd0)
                else $error("access refused while protection off");
        end
        // R8
        if (global_en && hit_vec == '0) begin
            no_hit_deny_chk: assert (!grant && err_class == 2'd0)
                else $error("no-hit access not refused with class 0");
        end
        // R7
        if (global_en && ok_vec != '0) begin
            any_ok_grant_chk: assert (grant)
                else $error("permitting region present but access refused");
        end
        // R10
        if (global_en && acc_kind == 2'd3) begin
            rsvd_kind_chk: assert (!grant)
                else $error("reserved kind granted");
        end
        // R8
        if (err_class == 2'd2) begin
            multi_cls_chk: assert ($countones(hit_vec) >= 2)
                else $error("overlap class with fewer than two hits");
        end
    end

endmodule

// File: tb/rgn_perm_chk_tb.sv
module rgn_perm_chk_tb;

    localparam int AW = 32;
    localparam int NR = 4;
    localparam int PW = 8;

    logic              clk = 1'b0;
    logic              global_en;
    logic [AW-1:0]     acc_addr;
    logic [2:0]        acc_master;
    logic [1:0]        acc_kind;
    logic              acc_super;
    logic [PW-1:0]     acc_pid;
    logic [NR-1:0]     rgn_valid;
    logic [NR*AW-1:0]  rgn_lo, rgn_hi;
    logic [NR*32-1:0]  rgn_rights;
    logic [NR*PW-1:0]  rgn_pid, rgn_pid_mask;
    logic              grant;
    logic [1:0]        err_class;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rgn_perm_chk u_dut (
        .global_en    (global_en),
        .acc_addr     (acc_addr),
        .acc_master   (acc_master),
        .acc_kind     (acc_kind),
        .acc_super    (acc_super),
        .acc_pid      (acc_pid),
        .rgn_valid    (rgn_valid),
        .rgn_lo       (rgn_lo),
        .rgn_hi       (rgn_hi),
        .rgn_rights   (rgn_rights),
        .rgn_pid      (rgn_pid),
        .rgn_pid_mask (rgn_pid_mask),
        .grant        (grant),
        .err_class    (err_class)
    );

    function automatic logic [31:0] put_priv(logic [31:0] w, int m, logic pe,
                                             logic [1:0] sup, logic [2:0] usr);
        logic [31:0] t = w;
        t[m*6 +: 6] = {pe, sup, usr};
        return t;
    endfunction

    function automatic logic [31:0] put_norm(logic [31:0] w, int m, logic rd, logic wr);
        logic [31:0] t = w;
        t[24 + 2*(m-4) +: 2] = {rd, wr};
        return t;
    endfunction

    task automatic clear_regions();
        rgn_valid    = '0;
        rgn_lo       = '0;
        rgn_hi       = '0;
        rgn_rights   = '0;
        rgn_pid      = '0;
        rgn_pid_mask = '0;
    endtask

    task automatic set_region(int r, logic [31:0] lo, logic [31:0] hi, logic [31:0] rights,
                              logic [7:0] pid, logic [7:0] mask);
        rgn_lo[r*32 +: 32]      = lo;
        rgn_hi[r*32 +: 32]      = hi;
        rgn_rights[r*32 +: 32]  = rights;
        rgn_pid[r*8 +: 8]       = pid;
        rgn_pid_mask[r*8 +: 8]  = mask;
        rgn_valid[r]            = 1'b1;
    endtask

    task automatic compare(string req, logic eg, logic [1:0] ec);
        checks++;
        if (grant !== eg || err_class !== ec) begin
            errors++;
            $display("FAIL %s: grant=%0b class=%0d expected grant=%0b class=%0d",
                     req, grant, err_class, eg, ec);
        end
    endtask

    task automatic probe(string req, logic [31:0] a, int m, logic [1:0] k, logic sup,
                         logic [7:0] pid, logic eg, logic [1:0] ec);
        @(negedge clk);
        acc_addr   = a;
        acc_master = 3'(m);
        acc_kind   = k;
        acc_super  = sup;
        acc_pid    = pid;
        #1;
        compare(req, eg, ec);
    endtask

    task automatic t_disabled();
        clear_regions();
        global_en = 1'b0;
        probe("R1", 32'h0000_1234, 0, 2'd1, 1'b0, 8'h00, 1'b1, 2'd0);
        set_region(0, 32'h0, 32'hFFFF_FFFF, 32'h0, 8'h00, 8'h00);
        probe("R1", 32'h8000_0000, 6, 2'd2, 1'b1, 8'h00, 1'b1, 2'd0);
        global_en = 1'b1;
        clear_regions();
        probe("R8", 32'h0000_1234, 0, 2'd0, 1'b1, 8'h00, 1'b0, 2'd0);
    endtask

    task automatic t_bounds();
        logic [31:0] rw;
        clear_regions();
        rw = put_priv(32'h0, 0, 1'b0, 2'd0, 3'd7);
        set_region(0, 32'h1000_0013, 32'h1000_00A0, rw, 8'h00, 8'h00);
        probe("R2", 32'h0FFF_FFFF, 0, 2'd0, 1'b0, 8'h00, 1'b0, 2'd0);
        probe("R2", 32'h1000_0000, 0, 2'd0, 1'b0, 8'h00, 1'b1, 2'd0);
        probe("R2", 32'h1000_00BF, 0, 2'd0, 1'b0, 8'h00, 1'b1, 2'd0);
        probe("R2", 32'h1000_00C0, 0, 2'd0, 1'b0, 8'h00, 1'b0, 2'd0);
        rgn_valid[0] = 1'b0;
        probe("R2", 32'h1000_0040, 0, 2'd0, 1'b0, 8'h00, 1'b0, 2'd0);
    endtask

    task automatic t_user();
        clear_regions();
        set_region(0, 32'h0, 32'h0000_FFFF, put_priv(32'h0, 1, 1'b0, 2'd0, 3'b100), 8'h00, 8'h00);
        probe("R3", 32'h100, 1, 2'd0, 1'b0, 8'h00, 1'b1, 2'd0);
        probe("R3", 32'h100, 1, 2'd1, 1'b0, 8'h00, 1'b0, 2'd1);
        probe("R3", 32'h100, 1, 2'd2, 1'b0, 8'h00, 1'b0, 2'd1);
        rgn_rights[31:0] = put_priv(32'h0, 1, 1'b0, 2'd0, 3'b001);
        probe("R3", 32'h100, 1, 2'd2, 1'b0, 8'h00, 1'b1, 2'd0);
        probe("R3", 32'h100, 1, 2'd0, 1'b0, 8'h00, 1'b0, 2'd1);
        rgn_rights[31:0] = put_priv(32'h0, 1, 1'b0, 2'd0, 3'b010);
        probe("R3", 32'h100, 1, 2'd1, 1'b0, 8'h00, 1'b1, 2'd0);
        rgn_rights[31:0] = put_priv(32'hFFFF_FFFF, 1, 1'b0, 2'd0, 3'b000);
        probe("R3", 32'h100, 1, 2'd0, 1'b0, 8'h00, 1'b0, 2'd1);
    endtask

    task automatic t_super();
        clear_regions();
        set_region(0, 32'h0, 32'h0000_FFFF, put_priv(32'h0, 2, 1'b0, 2'd0, 3'b000), 8'h00, 8'h00);
        probe("R4", 32'h200, 2, 2'd1, 1'b1, 8'h00, 1'b1, 2'd0);
        probe("R4", 32'h200, 2, 2'd2, 1'b1, 8'h00, 1'b1, 2'd0);
        probe("R4", 32'h200, 2, 2'd0, 1'b0, 8'h00, 1'b0, 2'd1);
        rgn_rights[31:0] = put_priv(32'h0, 2, 1'b0, 2'd1, 3'b010);
        probe("R4", 32'h200, 2, 2'd0, 1'b1, 8'h00, 1'b1, 2'd0);
        probe("R4", 32'h200, 2, 2'd1, 1'b1, 8'h00, 1'b0, 2'd1);
        probe("R4", 32'h200, 2, 2'd2, 1'b1, 8'h00, 1'b1, 2'd0);
        rgn_rights[31:0] = put_priv(32'h0, 2, 1'b0, 2'd2, 3'b001);
        probe("R4", 32'h200, 2, 2'd1, 1'b1, 8'h00, 1'b1, 2'd0);
        probe("R4", 32'h200, 2, 2'd2, 1'b1, 8'h00, 1'b0, 2'd1);
        rgn_rights[31:0] = put_priv(32'h0, 2, 1'b0, 2'd3, 3'b010);
        probe("R4", 32'h200, 2, 2'd1, 1'b1, 8'h00, 1'b1, 2'd0);
        probe("R4", 32'h200, 2, 2'd0, 1'b1, 8'h00, 1'b0, 2'd1);
    endtask

    task automatic t_normal();
        logic [31:0] rw;
        clear_regions();
        rw = put_norm(32'h0, 5, 1'b1, 1'b0);
        rw = put_norm(rw, 7, 1'b0, 1'b1);
        set_region(0, 32'h0, 32'h0000_FFFF, rw, 8'h00, 8'h00);
        probe("R5", 32'h300, 5, 2'd0, 1'b0, 8'h00, 1'b1, 2'd0);
        probe("R5", 32'h300, 5, 2'd0, 1'b1, 8'h00, 1'b1, 2'd0);
        probe("R5", 32'h300, 5, 2'd1, 1'b1, 8'h00, 1'b0, 2'd1);
        probe("R5", 32'h300, 7, 2'd1, 1'b0, 8'h00, 1'b1, 2'd0);
        probe("R5", 32'h300, 7, 2'd0, 1'b0, 8'h00, 1'b0, 2'd1);
        probe("R5", 32'h300, 4, 2'd0, 1'b0, 8'h00, 1'b0, 2'd1);
        rgn_rights[31:0] = 32'hFFFF_FFFF;
        probe("R5", 32'h300, 6, 2'd2, 1'b1, 8'h00, 1'b0, 2'd1);
    endtask

    task automatic t_pid();
        clear_regions();
        set_region(0, 32'h0, 32'h0000_FFFF, put_priv(32'h0, 0, 1'b1, 2'd0, 3'd7), 8'h5A, 8'h0F);
        probe("R6", 32'h40, 0, 2'd0, 1'b0, 8'h53, 1'b1, 2'd0);
        probe("R6", 32'h40, 0, 2'd0, 1'b0, 8'h6A, 1'b0, 2'd0);
        probe("R6", 32'h40, 0, 2'd0, 1'b0, 8'hA5, 1'b0, 2'd0);
        rgn_rights[31:0] = put_priv(32'h0, 0, 1'b0, 2'd0, 3'd7);
        probe("R6", 32'h40, 0, 2'd0, 1'b0, 8'h00, 1'b1, 2'd0);
    endtask

    task automatic t_overlap();
        clear_regions();
        set_region(0, 32'h0000_0000, 32'h0000_0FFF, put_priv(32'h0, 3, 1'b0, 2'd3, 3'b100), 8'h00, 8'h00);
        set_region(2, 32'h0000_0800, 32'h0000_1FFF, put_priv(32'h0, 3, 1'b0, 2'd3, 3'b010), 8'h00, 8'h00);
        probe("R7", 32'h0000_0900, 3, 2'd1, 1'b0, 8'h00, 1'b1, 2'd0);
        probe("R7", 32'h0000_0900, 3, 2'd0, 1'b0, 8'h00, 1'b1, 2'd0);
        probe("R8", 32'h0000_0900, 3, 2'd2, 1'b0, 8'h00, 1'b0, 2'd2);
        probe("R8", 32'h0000_1800, 3, 2'd0, 1'b0, 8'h00, 1'b0, 2'd1);
        probe("R10", 32'h0000_0900, 3, 2'd3, 1'b1, 8'h00, 1'b0, 2'd2);
        rgn_rights[31:0] = 32'hFFFF_FFFF;
        probe("R10", 32'h0000_0100, 0, 2'd3, 1'b1, 8'h00, 1'b0, 2'd1);
    endtask

    task automatic t_comb();
        clear_regions();
        set_region(1, 32'h2000, 32'h2FFF, put_priv(32'h0, 0, 1'b0, 2'd0, 3'd7), 8'h00, 8'h00);
        @(negedge clk);
        acc_master = 3'd0; acc_kind = 2'd0; acc_super = 1'b0; acc_pid = 8'h00;
        acc_addr = 32'h2100;
        #0.5;
        compare("R9", 1'b1, 2'd0);
        acc_addr = 32'h3000;
        #0.5;
        compare("R9", 1'b0, 2'd0);
        rgn_hi[63:32] = 32'h3000;
        #0.5;
        compare("R9", 1'b1, 2'd0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        global_en  = 1'b0;
        acc_addr   = '0;
        acc_master = '0;
        acc_kind   = '0;
        acc_super  = 1'b0;
        acc_pid    = '0;
        clear_regions();
        t_disabled();
        t_bounds();
        t_user();
        t_super();
        t_normal();
        t_pid();
        t_overlap();
        t_comb();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule